// File: doc/BRIEF.md
# Serial Command Front End with Pause

This block is the serial slave front end of a multi-channel settings device. It runs on a fast system clock and oversamples a four-wire serial link (serial clock, active-low select, serial data in, serial data out), plus an active-low pause input and a two-bit address strap. Once the select line falls, the block takes in an identification byte. It checks that byte against a fixed device-type nibble, two reserved zero bits and the strap value. A matching byte is followed by an instruction byte, which the block splits into a four-bit opcode, a two-bit register index and a two-bit channel index.

The opcode decides what happens next. A write opcode waits for one more byte before it reports. A read opcode reports straight away. It then takes a byte from the downstream register store and shifts it out on the data-out line, most significant bit first. All other opcodes report straight away and carry no data. Each finished command appears as a single-cycle strobe with its fields, so the storage logic downstream never sees serial timing. The data-out line is driven only while read bits are being shifted, which allows data-in and data-out to share a wire. While the pause input is held low, the transfer freezes and keeps its position in the sequence.

Top module: `spiCmdFront`

## Requirements
- R1: After reset no command is accepted until the select line has been seen high and then low. If select is already low at reset and stays low, serial traffic produces no strobe.
- R2: Serial input bits are taken on the rising serial clock edge, most significant bit first, and the bit position restarts at zero on every select falling edge.
- R3: The first byte is accepted only if bits 7:4 equal the TYPE_CODE parameter (default 0101), bits 3:2 are zero and bits 1:0 equal addrStrap. Otherwise no strobe is issued and data out stays disabled until select rises.
- R4: In the second byte, bits 7:4 form cmdOp, bits 3:2 form cmdReg and bits 1:0 form cmdPot.
- R5: A write opcode (default hex A and hex C, set in WR_OP_MASK) issues its strobe only after a third byte, and that byte appears on cmdData.
- R6: An opcode that is neither a write nor a read issues its strobe right after the second byte, with cmdData zero. Later bytes are ignored.
- R7: A read opcode (default hex 9 and hex B, set in RD_OP_MASK) issues its strobe right after the second byte, with cmdData zero. rdData is captured at the next falling serial clock edge and sent MSB first, one bit per falling edge. Data out is enabled from that edge until the eighth rising edge of the read byte.
- R8: soOe is low while select is high and at every moment outside the read phase.
- R9: Pulling holdN low while the serial clock is low freezes the transfer. Clock edges are ignored and soOe is low. Raising holdN while the clock is low resumes the same sequence.
- R10: A select rising edge in the middle of a sequence abandons it with no strobe. The next select falling edge starts a fresh identification byte.
- R11: cmdValid is high for exactly one system clock cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| csN | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Active-low pause |
| addrStrap | input | 2 | Strapped device address |
| rdData | input | 8 | Read byte from downstream storage |
| soData | output | 1 | Serial data out value |
| soOe | output | 1 | Output enable for the data-out three-state pad |
| cmdValid | output | 1 | Single-cycle command strobe |
| cmdOp | output | 4 | Decoded opcode |
| cmdReg | output | 2 | Decoded register index |
| cmdPot | output | 2 | Decoded channel index |
| cmdData | output | 8 | Write data byte, zero for other commands |

## Verification
The bench builds the block with its defaults: type nibble 0101, writes on opcodes A and C, reads on 9 and B, and two synchronizer stages. The strap is tied to binary 10. With these values, one vector table can reach every opcode class, each of the three ways an identification byte can fail, and read data patterns with alternating bits. The serial clock half period is eight system cycles, which leaves room for the synchronizer latency. This lets the bench place pauses in the middle of both the instruction byte and the read byte.

// File: rtl/spiFrontPkg.sv
package spiFrontPkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int IDX_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_INSTR,
    ST_DATA,
    ST_RDWAIT,
    ST_READ,
    ST_IGNORE
  } frontState_t;

  // Events reported by the datapath to the control.
  typedef struct packed {
    logic              csFall;
    logic              csRise;
    logic              sckFall;
    logic              byteDone;
    logic [BYTE_W-1:0] rxByte;
  } pathEvt_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic clrCount;
    logic latchInstr;
    logic latchData;
    logic loadTx;
    logic shiftTx;
    logic stopTx;
  } ctrlStb_t;
endpackage

// File: rtl/spiSync.sv
module spiSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES > 1) begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end else begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= RESET_VAL;
        else       pipe <= d;
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spiFrontPath.sv
module spiFrontPath
  import spiFrontPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              siIn,
  input  logic              holdNIn,
  input  logic [BYTE_W-1:0] rdData,
  input  ctrlStb_t          stb,
  output pathEvt_t          evt,
  output logic [OP_W-1:0]   cmdOp,
  output logic [IDX_W-1:0]  cmdReg,
  output logic [IDX_W-1:0]  cmdPot,
  output logic [BYTE_W-1:0] cmdData,
  output logic              soData,
  output logic              soOe
);
  logic sckS, csS, siS, holdS;
  logic sckPrev, csPrev, paused, active, sckRise, txLive;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, rxNext, instrReg, dataReg, txShift;

  // Select syncs reset to "selected" so only a real high-then-low counts.
  spiSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSck  (.clk(clk), .rstN(rstN), .d(sckIn),   .q(sckS));
  spiSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uCs   (.clk(clk), .rstN(rstN), .d(csNIn),   .q(csS));
  spiSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uSi   (.clk(clk), .rstN(rstN), .d(siIn),    .q(siS));
  spiSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uHold (.clk(clk), .rstN(rstN), .d(holdNIn), .q(holdS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b0;
      paused  <= 1'b0;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      if (!sckS) paused <= !holdS;  // pause state only changes while clock low
    end
  end

  assign active       = !csS && !paused;
  assign sckRise      = sckS && !sckPrev && active;
  assign rxNext       = {rxShift[BYTE_W-2:0], siS};
  assign evt.csFall   = !csS && csPrev;
  assign evt.csRise   = csS && !csPrev;
  assign evt.sckFall  = !sckS && sckPrev && active;
  assign evt.byteDone = sckRise && (bitCnt == CNT_W'(BYTE_W - 1));
  assign evt.rxByte   = rxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      if (stb.clrCount)  bitCnt <= '0;
      else if (sckRise)  bitCnt <= bitCnt + 1'b1;
      if (sckRise)       rxShift <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrReg <= '0;
      dataReg  <= '0;
    end else begin
      if (stb.latchInstr) begin
        instrReg <= rxNext;
        dataReg  <= '0;
      end
      if (stb.latchData) dataReg <= rxNext;
    end
  end

  assign cmdOp   = instrReg[BYTE_W-1 -: OP_W];
  assign cmdReg  = instrReg[2*IDX_W-1 -: IDX_W];
  assign cmdPot  = instrReg[IDX_W-1:0];
  assign cmdData = dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      txLive  <= 1'b0;
    end else begin
      if (stb.loadTx)       txShift <= rdData;
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (stb.stopTx)       txLive <= 1'b0;
      else if (stb.loadTx)  txLive <= 1'b1;
    end
  end

  assign soData = txShift[BYTE_W-1];
  assign soOe   = txLive && !paused && !csS;

  // R2
  bit_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.csFall |=> (bitCnt == '0));

  // R9
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    paused |=> $stable(rxShift));
endmodule

// File: rtl/spiFrontCtrl.sv
module spiFrontCtrl
  import spiFrontPkg::*;
#(
  parameter logic [OP_W-1:0] TYPE_CODE  = 4'b0101,
  parameter logic [15:0]     WR_OP_MASK = 16'h1400,
  parameter logic [15:0]     RD_OP_MASK = 16'h0A00
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathEvt_t         evt,
  input  logic [IDX_W-1:0] addrStrap,
  output ctrlStb_t         stb,
  output frontState_t      state,
  output logic             cmdValid
);
  frontState_t     nextState;
  logic            fire, idOk;
  logic [OP_W-1:0] rxOp;

  assign rxOp = evt.rxByte[BYTE_W-1 -: OP_W];
  assign idOk = (rxOp == TYPE_CODE)
             && (evt.rxByte[2*IDX_W-1 -: IDX_W] == '0)
             && (evt.rxByte[IDX_W-1:0] == addrStrap);

  always_comb begin
    stb       = '0;
    nextState = state;
    fire      = 1'b0;
    if (evt.csRise) begin
      nextState  = ST_IDLE;
      stb.stopTx = 1'b1;
    end else if (evt.csFall) begin
      nextState    = ST_ID;
      stb.clrCount = 1'b1;
      stb.stopTx   = 1'b1;
    end else begin
      unique case (state)
        ST_ID: if (evt.byteDone) nextState = idOk ? ST_INSTR : ST_IGNORE;
        ST_INSTR: if (evt.byteDone) begin
          stb.latchInstr = 1'b1;
          if (WR_OP_MASK[rxOp]) begin
            nextState = ST_DATA;
          end else begin
            fire      = 1'b1;
            nextState = RD_OP_MASK[rxOp] ? ST_RDWAIT : ST_IGNORE;
          end
        end
        ST_DATA: if (evt.byteDone) begin
          stb.latchData = 1'b1;
          fire          = 1'b1;
          nextState     = ST_IGNORE;
        end
        ST_RDWAIT: if (evt.sckFall) begin
          stb.loadTx = 1'b1;
          nextState  = ST_READ;
        end
        ST_READ: begin
          if (evt.sckFall) stb.shiftTx = 1'b1;
          if (evt.byteDone) begin
            stb.stopTx = 1'b1;
            nextState  = ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdValid <= 1'b0;
    end else begin
      state    <= nextState;
      cmdValid <= fire;
    end
  end

  // R11
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R3
  id_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ID && evt.byteDone && !idOk && !evt.csRise) |=> (state == ST_IGNORE && !cmdValid));

  // R5
  data_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> !cmdValid);
endmodule

// File: rtl/spiCmdFront.sv
module spiCmdFront
  import spiFrontPkg::*;
#(
  parameter logic [3:0]  TYPE_CODE   = 4'b0101,
  parameter logic [15:0] WR_OP_MASK  = 16'h1400,
  parameter logic [15:0] RD_OP_MASK  = 16'h0A00,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       si,
  input  logic       holdN,
  input  logic [1:0] addrStrap,
  input  logic [7:0] rdData,
  output logic       soData,
  output logic       soOe,
  output logic       cmdValid,
  output logic [3:0] cmdOp,
  output logic [1:0] cmdReg,
  output logic [1:0] cmdPot,
  output logic [7:0] cmdData
);
  pathEvt_t    evt;
  ctrlStb_t    stb;
  frontState_t ctrlState;

  spiFrontPath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .siIn(si), .holdNIn(holdN),
    .rdData(rdData), .stb(stb), .evt(evt),
    .cmdOp(cmdOp), .cmdReg(cmdReg), .cmdPot(cmdPot), .cmdData(cmdData),
    .soData(soData), .soOe(soOe)
  );

  spiFrontCtrl #(.TYPE_CODE(TYPE_CODE), .WR_OP_MASK(WR_OP_MASK), .RD_OP_MASK(RD_OP_MASK)) uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt), .addrStrap(addrStrap),
    .stb(stb), .state(ctrlState), .cmdValid(cmdValid)
  );

  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> (ctrlState == ST_READ));

  // R7
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_RDWAIT && $past(ctrlState) == ST_INSTR) |-> cmdValid);
endmodule

// File: tb/spiCmdFront_test.sv
module spiCmdFront_test;
  localparam int HALF = 8;
  // {id, instr, data, rdByte}; strap is 2'b10
  localparam logic [31:0] VEC [10] = '{
    32'h52A63C00, 32'h52C9A500, 32'h529B11C3, 32'h52B4225A, 32'h51A03300,
    32'h56134400, 32'h42A05500, 32'h522E6600, 32'h52FF7700, 32'h52807700
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, sck = 1'b0, csN = 1'b0, si = 1'b0, holdN = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [7:0] rdData = 8'h00;
  logic soData, soOe, cmdValid;
  logic [3:0] cmdOp;
  logic [1:0] cmdReg, cmdPot;
  logic [7:0] cmdData;

  spiCmdFront uut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .holdN(holdN),
    .addrStrap(strap), .rdData(rdData), .soData(soData), .soOe(soOe),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReg(cmdReg), .cmdPot(cmdPot), .cmdData(cmdData)
  );

  int total = 0, bad = 0, strobes = 0, wide = 0;
  logic prevV = 1'b0;
  logic [3:0] gOp;
  logic [1:0] gReg, gPot;
  logic [7:0] gData;

  always @(negedge clk) begin
    if (cmdValid) begin
      strobes = strobes + 1;
      gOp = cmdOp; gReg = cmdReg; gPot = cmdPot; gData = cmdData;
      if (prevV) wide = wide + 1;
    end
    prevV = cmdValid;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spiBit(input logic b, output logic rb, output logic oe);
    si = b;
    repeat (HALF) @(negedge clk);
    rb = soData; oe = soOe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx, output int oeCnt);
    logic rb, oe;
    oeCnt = 0;
    for (int k = 7; k >= 0; k--) begin
      spiBit(tx[k], rb, oe);
      rx[k] = rb;
      oeCnt += int'(oe);
    end
  endtask

  task automatic selLow();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic selHigh();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic pauseHere(output logic oeHeld);
    repeat (2) @(negedge clk);
    holdN = 1'b0;
    repeat (8) @(negedge clk);
    oeHeld = soOe;
    for (int p = 0; p < 3; p++) begin
      si = ~si; sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    holdN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rx1, rx2, rx3;
    int oe1, oe2, oe3, base;
    logic rb, oe, oeHeld;
    logic [7:0] rdGot;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset soOe", soOe, 0);
    chk("R11 reset cmdValid", cmdValid, 0);

    // R1: select low since reset, never seen falling
    spiByte(8'h52, rx1, oe1);
    spiByte(8'h10, rx2, oe2);
    repeat (2*HALF) @(negedge clk);
    chk("R1 no strobe without select fall", strobes, 0);
    chk("R1 soOe idle", oe1 + oe2, 0);
    csN = 1'b1;
    repeat (2*HALF) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic [7:0] id, ins, dat, rd;
      logic idOk, isWr, isRd;
      {id, ins, dat, rd} = VEC[i];
      idOk = (id[7:4] == 4'b0101) && (id[3:2] == 2'b00) && (id[1:0] == strap);
      isWr = (ins[7:4] == 4'hA) || (ins[7:4] == 4'hC);
      isRd = (ins[7:4] == 4'h9) || (ins[7:4] == 4'hB);
      rdData = rd;
      base = strobes;
      selLow();
      spiByte(id, rx1, oe1);
      spiByte(ins, rx2, oe2);
      repeat (HALF) @(negedge clk);
      chk($sformatf("R5 R6 early strobe v%0d", i), strobes - base, int'(idOk && !isWr));
      spiByte(dat, rx3, oe3);
      repeat (HALF) @(negedge clk);
      chk($sformatf("R3 strobe count v%0d", i), strobes - base, int'(idOk));
      chk($sformatf("R8 soOe before read v%0d", i), oe1 + oe2, 0);
      chk($sformatf("R7 soOe read byte v%0d", i), oe3, (idOk && isRd) ? 8 : 0);
      chk($sformatf("R7 released v%0d", i), soOe, 0);
      if (idOk && isRd) chk($sformatf("R7 read data v%0d", i), rx3, rd);
      if (idOk) begin
        chk($sformatf("R4 op v%0d", i), gOp, ins[7:4]);
        chk($sformatf("R4 reg v%0d", i), gReg, ins[3:2]);
        chk($sformatf("R4 pot v%0d", i), gPot, ins[1:0]);
        chk($sformatf("R5 R6 data v%0d", i), gData, isWr ? dat : 8'h00);
      end
      selHigh();
      chk($sformatf("R8 select high v%0d", i), soOe, 0);
    end

    // R10: abort mid-instruction, then a clean command
    base = strobes;
    selLow();
    spiByte(8'h52, rx1, oe1);
    for (int k = 7; k >= 4; k--) spiBit(1'b1, rb, oe);
    selHigh();
    chk("R10 abort gives no strobe", strobes - base, 0);
    selLow();
    spiByte(8'h52, rx1, oe1);
    spiByte(8'h2E, rx2, oe2);
    repeat (HALF) @(negedge clk);
    chk("R10 restart strobe", strobes - base, 1);
    chk("R2 R10 restart op", gOp, 4'h2);
    chk("R2 R10 restart reg", gReg, 2'd3);
    chk("R2 R10 restart pot", gPot, 2'd2);
    selHigh();

    // R9: pauses inside instruction byte and inside read byte
    base = strobes;
    rdData = 8'h96;
    selLow();
    spiByte(8'h52, rx1, oe1);
    for (int k = 7; k >= 4; k--) spiBit(ins_bit(8'hB7, k), rb, oe);
    pauseHere(oeHeld);
    for (int k = 3; k >= 0; k--) spiBit(ins_bit(8'hB7, k), rb, oe);
    for (int k = 7; k >= 5; k--) begin spiBit(1'b0, rb, oe); rdGot[k] = rb; end
    pauseHere(oeHeld);
    chk("R9 soOe low while paused", oeHeld, 0);
    chk("R9 soOe back after resume", soOe, 1);
    for (int k = 4; k >= 0; k--) begin spiBit(1'b0, rb, oe); rdGot[k] = rb; end
    repeat (HALF) @(negedge clk);
    chk("R9 one strobe across pause", strobes - base, 1);
    chk("R9 op", gOp, 4'hB);
    chk("R9 reg", gReg, 2'd1);
    chk("R9 pot", gPot, 2'd3);
    chk("R9 read data", rdGot, 8'h96);
    selHigh();

    chk("R11 strobe one cycle wide", wide, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic ins_bit(input logic [7:0] v, input int k);
    return v[k];
  endfunction
endmodule